// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

Once reset is released, this block fetches a configuration image from an external serial EEPROM and turns it into register writes that replace the device's power-on defaults. It drives a byte-level SMBus master engine through a request/response handshake. Each request carries one operation: start plus device address, write byte, read byte, or stop. The records it extracts come out on a simple register write port.

The EEPROM bus has a single master and no arbitration. The loader owns that bus from reset until it finishes, and only then grants it to the hot-plug expander logic. Parsed records are held in a small pending store. They are written to the registers only after the image checksum has passed and the final stop has been issued. A bad checksum, a missing acknowledge or an oversize image leaves the defaults untouched. In every case the block ends with a done flag and an error flag that stay stable until the next reset.

Top module: `cfg_image_loader`

## Requirements
- R1: One cycle after reset is released, the first request is a start whose address byte is the 7-bit device address followed by a 0 write bit (0xA0 by default). The operation codes are start=0, write=1, read=2 and stop=3.
- R2: After that start is acknowledged, the block writes two pointer bytes of 0x00, then issues a repeated start with the read bit set (0xA1 by default).
- R3: Bytes are read sequentially. Every read asks the master to ACK except the final one of the image, which is not acknowledged. A stop follows that final read.
- R4: The image is laid out as follows, all fields least significant byte first: a 16-bit record count; then that many records, each a 16-bit register address and a 32-bit data word; then one checksum byte.
- R5: When the byte sum of the whole image is 0 modulo 256, the records are written after the stop completes, one per cycle and in image order. The done flag rises in the cycle after the last write.
- R6: When the checksum does not match, no register write occurs, and both the done and error flags are set.
- R7: When a start or write phase is not acknowledged, the block issues a stop next, reads nothing more and writes nothing. It then sets the done and error flags.
- R8: When the record count exceeds the pending store depth (8), exactly one more byte is read without ACK, a stop follows, and the load ends in error with no writes.
- R9: Done and error are 0 during reset. Once done is set, done and error do not change until reset, and no register write follows.
- R10: The hot-plug bus grant equals the done flag. While it is high the loader raises no bus request.
- R11: An image with a record count of 0 is three bytes long. It ends with done set, error clear and no writes.
- R12: A request stays asserted with unchanged operation, byte and ACK choice until the engine returns a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | output | 1 | Bus operation requested |
| req_op | output | 2 | Operation: 0 start, 1 write, 2 read, 3 stop |
| req_byte | output | 8 | Address byte for start, data byte for write |
| req_rd_ack | output | 1 | For a read: master ACKs the byte when 1 |
| rsp_valid | input | 1 | One-cycle pulse: requested operation completed |
| rsp_nack | input | 1 | With rsp_valid: slave did not acknowledge |
| rsp_data | input | 8 | With rsp_valid on a read: received byte |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 16 | Register address |
| reg_wr_data | output | 32 | Register data |
| load_done | output | 1 | Load finished (sticky) |
| load_error | output | 1 | Load failed, defaults kept (sticky) |
| hp_bus_grant | output | 1 | Bus handed to hot-plug logic |

## Verification
The embedded assertions check the following on every cycle: a request is held until it is answered, done and error are sticky, no request is raised while the hot-plug side holds the bus, writes never coexist with done or error, and the pending store is never indexed past its depth. Other properties depend on a specific image and only the bench scenarios can show them. These are the exact operation sequence, the position of the unacknowledged read, field assembly in byte order, commit ordering, and the all-or-nothing outcome for bad checksums, missing acknowledges and oversize counts.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [3:0] {
        S_BOOT, S_ADDR_W, S_PTR_HI, S_PTR_LO, S_ADDR_R,
        S_READ, S_STOP, S_COMMIT, S_DONE
    } ldr_state_e;
endpackage

// File: rtl/cfg_sum8.sv
module cfg_sum8 (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [7:0] din,
    output logic       zero
);
    logic [7:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (en) sum_d = sum_q + din;
    end

    always_ff @(posedge clk) begin
        if (rst) sum_q <= '0;
        else     sum_q <= sum_d;
    end

    assign zero = (sum_q == 8'd0);
endmodule

// File: rtl/cfg_pend_store.sv
module cfg_pend_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW:0]   wr_idx,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [IW:0]   rd_idx,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam logic [IW:0] DEPTH_W = (IW+1)'(DEPTH);

    logic [AW+DW-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == (IW+1)'(g))
                mem_q[g] <= {wr_data, wr_addr};
        end
    end

    logic [AW+DW-1:0] rd_word;
    always_comb begin
        rd_word = '0;
        if (rd_idx < DEPTH_W) rd_word = mem_q[rd_idx[IW-1:0]];
    end
    assign rd_addr = rd_word[AW-1:0];
    assign rd_data = rd_word[AW+DW-1:AW];

    assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_idx < DEPTH_W);
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
    import cfg_ldr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int DEPTH  = 8,
    parameter int REG_AW = 16,
    parameter int REG_DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    output logic              req_valid,
    output logic [1:0]        req_op,
    output logic [7:0]        req_byte,
    output logic              req_rd_ack,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    input  logic [7:0]        rsp_data,
    output logic              reg_wr_en,
    output logic [REG_AW-1:0] reg_wr_addr,
    output logic [REG_DW-1:0] reg_wr_data,
    output logic              load_done,
    output logic              load_error,
    output logic              hp_bus_grant
);
    localparam int REC_W     = REG_AW + REG_DW;
    localparam int REC_BYTES = REC_W / 8;
    localparam int IW        = $clog2(DEPTH);
    localparam int RB_W      = $clog2(REC_BYTES) + 1;
    localparam int POS_W     = 20;
    localparam logic [15:0]     DEPTH16 = 16'(DEPTH);
    localparam logic [RB_W-1:0] RB_LAST = RB_W'(REC_BYTES - 1);
    localparam logic [POS_W-1:0] POS2   = POS_W'(2);

    typedef struct packed {
        ldr_state_e       st;
        logic [POS_W-1:0] pos;
        logic [15:0]      count;
        logic [REC_W-1:0] rec;
        logic [RB_W-1:0]  rbyte;
        logic [IW:0]      widx;
        logic             fail;
        logic             done;
        logic             err;
    } ldr_t;

    ldr_t q, d;
    bus_op_e op;
    logic sum_en, sum_zero, st_we, too_big, last_rd;
    logic [POS_W-1:0] last_pos;
    logic [REC_W-1:0] rec_next;

    assign too_big  = q.count > DEPTH16;
    assign last_pos = POS2 + POS_W'(REC_BYTES) * POS_W'(q.count);
    assign last_rd  = (q.pos >= POS2) && (too_big || q.pos == last_pos);
    assign rec_next = {rsp_data, q.rec[REC_W-1:8]};

    always_comb begin
        d          = q;
        sum_en     = 1'b0;
        st_we      = 1'b0;
        req_valid  = 1'b0;
        op         = OP_STOP;
        req_byte   = 8'h00;
        req_rd_ack = 1'b0;
        reg_wr_en  = 1'b0;
        case (q.st)
            S_BOOT: d.st = S_ADDR_W;
            S_ADDR_W, S_PTR_HI, S_PTR_LO, S_ADDR_R: begin
                req_valid = 1'b1;
                op        = (q.st == S_ADDR_W || q.st == S_ADDR_R) ? OP_START : OP_WRITE;
                if (q.st == S_ADDR_W) req_byte = {DEV_ADDR, 1'b0};
                if (q.st == S_ADDR_R) req_byte = {DEV_ADDR, 1'b1};
                if (rsp_valid) begin
                    if (rsp_nack) begin
                        d.fail = 1'b1;
                        d.st   = S_STOP;
                    end else begin
                        case (q.st)
                            S_ADDR_W: d.st = S_PTR_HI;
                            S_PTR_HI: d.st = S_PTR_LO;
                            S_PTR_LO: d.st = S_ADDR_R;
                            default:  d.st = S_READ;
                        endcase
                    end
                end
            end
            S_READ: begin
                req_valid  = 1'b1;
                op         = OP_READ;
                req_rd_ack = !last_rd;
                if (rsp_valid) begin
                    sum_en = 1'b1;
                    d.pos  = q.pos + 1'b1;
                    if (q.pos == '0)
                        d.count[7:0] = rsp_data;
                    else if (q.pos == POS_W'(1))
                        d.count[15:8] = rsp_data;
                    else if (!too_big && q.pos < last_pos) begin
                        d.rec = rec_next;
                        if (q.rbyte == RB_LAST) begin
                            st_we   = 1'b1;
                            d.widx  = q.widx + 1'b1;
                            d.rbyte = '0;
                        end else begin
                            d.rbyte = q.rbyte + 1'b1;
                        end
                    end
                    if (last_rd) begin
                        d.st = S_STOP;
                        if (too_big) d.fail = 1'b1;
                    end
                end
            end
            S_STOP: begin
                req_valid = 1'b1;
                op        = OP_STOP;
                if (rsp_valid) begin
                    if (q.fail || !sum_zero) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                        d.st   = S_DONE;
                    end else if (q.count == 16'd0) begin
                        d.done = 1'b1;
                        d.st   = S_DONE;
                    end else begin
                        d.widx = '0;
                        d.st   = S_COMMIT;
                    end
                end
            end
            S_COMMIT: begin
                reg_wr_en = 1'b1;
                d.widx    = q.widx + 1'b1;
                if (16'(q.widx) + 16'd1 == q.count) begin
                    d.done = 1'b1;
                    d.st   = S_DONE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= S_BOOT;
        end else begin
            q <= d;
        end
    end

    cfg_sum8 u_sum (
        .clk (clk), .rst (rst), .en (sum_en), .din (rsp_data), .zero (sum_zero)
    );

    cfg_pend_store #(.DEPTH(DEPTH), .AW(REG_AW), .DW(REG_DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (st_we),
        .wr_idx  (q.widx),
        .wr_addr (rec_next[REG_AW-1:0]),
        .wr_data (rec_next[REC_W-1:REG_AW]),
        .rd_idx  (q.widx),
        .rd_addr (reg_wr_addr),
        .rd_data (reg_wr_data)
    );

    assign req_op       = op;
    assign load_done    = q.done;
    assign load_error   = q.err;
    assign hp_bus_grant = q.done;

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_op)
                                       && $stable(req_byte) && $stable(req_rd_ack)));
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        load_done |=> (load_done && $stable(load_error)));
    assert_no_req_granted_R10: assert property (@(posedge clk) disable iff (rst)
        hp_bus_grant |-> !req_valid);
    assert_clean_write_R5: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> (!load_error && !load_done && !req_valid));
    assert_err_done_R6: assert property (@(posedge clk) disable iff (rst)
        load_error |-> load_done);
endmodule

// File: tb/test_cfg_image_loader.sv
module test_cfg_image_loader;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int LAT = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid, req_rd_ack, rsp_valid, rsp_nack;
    logic [1:0] req_op;
    logic [7:0] req_byte, rsp_data;
    logic reg_wr_en, load_done, load_error, hp_bus_grant;
    logic [15:0] reg_wr_addr;
    logic [31:0] reg_wr_data;

    cfg_image_loader i_cfg_image_loader (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_byte(req_byte), .req_rd_ack(req_rd_ack), .rsp_valid(rsp_valid),
        .rsp_nack(rsp_nack), .rsp_data(rsp_data), .reg_wr_en(reg_wr_en),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .load_done(load_done), .load_error(load_error), .hp_bus_grant(hp_bus_grant)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vec = 0, bad = 0, cyc = 0;
    logic [7:0] img[$];
    int eop[$], eby[$], eack[$];
    logic [15:0] ewa[$];
    logic [31:0] ewd[$];
    int nack_at = -1, ctrl_i = 0, rd_i = 0, cnt = 0;

    task automatic chk(string req, int act, int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural engine and per-clock reference comparison
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
        if (rst) begin
            rsp_valid = 0; rsp_nack = 0; rsp_data = 0; cnt = 0;
        end else begin
            chk("R10 grant", int'(hp_bus_grant), int'(load_done));
            if (hp_bus_grant) chk("R10 idle bus", int'(req_valid), 0);
            if (reg_wr_en) begin
                if (ewa.size() == 0) chk("R6 unexpected write", 1, 0);
                else begin
                    chk("R5 addr", int'(reg_wr_addr), int'(ewa.pop_front()));
                    chk("R5 data", int'(reg_wr_data), int'(ewd.pop_front()));
                end
            end
            if (rsp_valid) begin
                rsp_valid = 0; rsp_nack = 0;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) rsp_valid = 1;
            end else if (req_valid) begin
                if (eop.size() == 0) chk("R3 unexpected op", int'(req_op), -1);
                else begin
                    int o, b, a;
                    o = eop.pop_front(); b = eby.pop_front(); a = eack.pop_front();
                    chk("R1 R2 R3 op", int'(req_op), o);
                    if (o <= 1) chk("R1 R2 byte", int'(req_byte), b);
                    if (o == 2) chk("R3 read ack", int'(req_rd_ack), a);
                end
                rsp_nack = 0;
                if (req_op <= 2'd1) begin
                    rsp_nack = (ctrl_i == nack_at);
                    ctrl_i++;
                end
                if (req_op == 2'd2) begin
                    rsp_data = (rd_i < img.size()) ? img[rd_i] : 8'hFF;
                    rd_i++;
                end
                cnt = LAT;
            end
        end
    end

    // build an image and the expectations from the requirements
    task automatic run(string name, int count, int bad_sum, int nk, int seed);
        logic [7:0] s;
        int err, nbytes;
        img.delete(); eop.delete(); eby.delete(); eack.delete(); ewa.delete(); ewd.delete();
        img.push_back(8'(count)); img.push_back(8'(count >> 8));
        for (int i = 0; i < count && i < DEPTH + 2; i++) begin
            logic [15:0] a; logic [31:0] dv;
            a  = 16'(16'h0100 + 4*i + seed);
            dv = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(seed * 7);
            for (int k = 0; k < 2; k++) img.push_back(a[8*k +: 8]);
            for (int k = 0; k < 4; k++) img.push_back(dv[8*k +: 8]);
            if (count <= DEPTH) begin ewa.push_back(a); ewd.push_back(dv); end
        end
        s = 0;
        foreach (img[i]) s += img[i];
        img.push_back(8'(8'd0 - s + 8'(bad_sum)));
        err = (nk >= 0) || (count > DEPTH) || (bad_sum != 0);
        // R1 R2: address write, two pointer bytes, repeated start for read
        eop.push_back(0); eby.push_back(8'hA0); eack.push_back(0);
        if (nk != 0) begin eop.push_back(1); eby.push_back(0); eack.push_back(0); end
        if (nk != 0 && nk != 1) begin eop.push_back(1); eby.push_back(0); eack.push_back(0); end
        if (nk < 0 || nk > 2) begin eop.push_back(0); eby.push_back(8'hA1); eack.push_back(0); end
        if (nk < 0) begin
            nbytes = (count > DEPTH) ? 3 : 3 + 6*count;   // R4 R8
            for (int i = 0; i < nbytes; i++) begin
                eop.push_back(2); eby.push_back(0); eack.push_back(i != nbytes-1);
            end
        end
        eop.push_back(3); eby.push_back(0); eack.push_back(0);
        if (err) begin ewa.delete(); ewd.delete(); end
        nack_at = nk;
        @(negedge clk); rst = 1; ctrl_i = 0; rd_i = 0;
        repeat (3) @(negedge clk);
        chk({name, " R9 reset done"}, int'(load_done), 0);
        chk({name, " R9 reset error"}, int'(load_error), 0);
        chk({name, " R5 reset no write"}, int'(reg_wr_en), 0);
        rst = 0;
        for (int t = 0; t < 5000 && !load_done; t++) @(negedge clk);
        chk({name, " R9 done"}, int'(load_done), 1);
        chk({name, " R6 R7 R8 R11 error"}, int'(load_error), err);
        chk({name, " R3 ops left"}, eop.size(), 0);
        chk({name, " R5 writes left"}, ewa.size(), 0);
        repeat (6) @(negedge clk);
        chk({name, " R9 done held"}, int'(load_done), 1);
        chk({name, " R9 error held"}, int'(load_error), err);
    endtask

    initial begin
        rsp_valid = 0; rsp_nack = 0; rsp_data = 0;
        run("good3", 3, 0, -1, 1);
        run("count0 R11", 0, 0, -1, 0);
        run("full8", 8, 0, -1, 5);
        run("badsum R6", 2, 1, -1, 3);
        run("nack_addr R7", 1, 0, 0, 0);
        run("nack_ptr R7", 1, 0, 2, 0);
        run("nack_raddr R7", 1, 0, 3, 0);
        run("oversize R8", 9, 0, -1, 2);
        run("good1", 1, 0, -1, 9);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule